// File: doc/BRIEF.md
# 4-bit Integer Tile Multiply-Accumulate Engine

This block computes one 8x8 output tile D = A·B + C, where A is an 8x32 matrix and B a 32x8 matrix of 4-bit integers, and C and D hold 32-bit integers. Each of A and B is read as signed or unsigned according to its own flag. Every operand and result enters or leaves the block as a single wide packed vector.

A start pulse, sampled while the engine is idle, captures all three operand vectors and both flags. The engine then handles one reduction index per clock for all 64 outputs at once, so a tile takes 32 compute cycles. At the end it writes the 64 results into an output register and raises a one-cycle done pulse. The result stays on the output until the next tile completes. A new start can be given in the same cycle as that done pulse, so tiles can run back to back.

Top module: `imma_tile_engine`

## Requirements
- R1: Each output satisfies D[i][j] = C[i][j] + sum over k = 0..31 of A[i][k]·B[k][j], for all 0 <= i, j <= 7.
- R2: Operand packing: A[i][k] is a_vec_i[128*i + 4*k +: 4]. B[k][j] is b_vec_i[128*j + 4*k +: 4]. C[i][j] is c_vec_i[32*(8*i+j) +: 32], and D[i][j] sits at the same position in d_vec_o.
- R3: When a_signed_i = 1, A elements are two's complement values in -8..7; when it is 0 they are 0..15. b_signed_i controls B in the same way, independently of A.
- R4: Accumulation wraps modulo 2^32 and never saturates.
- R5: A start_i sampled high while busy_o is low captures A, B, C and both signedness flags, and busy_o is high from the next cycle on. Input changes after that edge have no effect on the tile.
- R6: A start_i sampled while busy_o is high is ignored. The running tile's result and timing are unchanged, and no extra tile follows.
- R7: busy_o stays high for exactly 32 cycles. done_o is high for exactly one cycle, the cycle right after busy_o falls, and never while busy_o is high.
- R8: d_vec_o changes only at the edge that raises done_o. It holds its value at all other times, including while the next tile runs.
- R9: A start_i sampled during the done_o cycle is accepted, and a new tile begins at once.
- R10: After synchronous reset, busy_o and done_o are 0 and d_vec_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request; sampled only while idle |
| a_signed_i | input | 1 | 1: A elements are two's complement |
| b_signed_i | input | 1 | 1: B elements are two's complement |
| a_vec_i | input | 1024 | A matrix, 8 rows of 32 four-bit elements |
| b_vec_i | input | 1024 | B matrix, 8 columns of 32 four-bit elements |
| c_vec_i | input | 2048 | C matrix, 64 32-bit addends |
| d_vec_o | output | 2048 | D matrix, 64 32-bit results |
| busy_o | output | 1 | Tile computation in progress |
| done_o | output | 1 | One-cycle pulse when d_vec_o is updated |

## Verification
Two events can meet in one cycle. The first is a tile finishing, which updates d_vec_o and pulses done_o. The second is a start request, which launches the next tile. The bench asserts start_i in the exact done cycle and expects a new run with no idle gap, while the old result stays on d_vec_o until the second tile completes. It also holds start_i high through the last busy cycle with different operands and expects that request to be dropped. The behavioural model in the bench judges every cycle, comparing busy, done and the full result vector.

// File: rtl/imma_pkg.sv
package imma_pkg;
  localparam int ROWS_DEF  = 8;
  localparam int COLS_DEF  = 8;
  localparam int DEPTH_DEF = 32;
  localparam int EW_DEF    = 4;
  localparam int AW_DEF    = 32;
endpackage

// File: rtl/imma_operand_shift.sv
// Holds one operand matrix as LANES lanes of DEPTH elements. Each step
// shifts every lane by one element, so the current element is always the
// lowest one and no wide selection mux is needed.
module imma_operand_shift #(
  parameter int LANES = 8,
  parameter int DEPTH = 32,
  parameter int EW    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   step,
  input  logic                   sgn_i,
  input  logic [LANES*DEPTH*EW-1:0] vec_i,
  output logic                   sgn_o,
  output logic [LANES*EW-1:0]    nib_o
);
  localparam int LW = DEPTH * EW;

  logic sgn_q;

  always_ff @(posedge clk) begin
    if (rst)       sgn_q <= 1'b0;
    else if (load) sgn_q <= sgn_i;
  end
  assign sgn_o = sgn_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst)       sh_q <= '0;
      else if (load) sh_q <= vec_i[l*LW +: LW];
      else if (step) sh_q <= sh_q >> EW;
    end
    assign nib_o[l*EW +: EW] = sh_q[EW-1:0];
  end
endmodule

// File: rtl/imma_mac_cell.sv
// One output element: a 32-bit accumulator plus the result register.
module imma_mac_cell #(
  parameter int EW = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          last,
  input  logic [AW-1:0] c_i,
  input  logic [EW-1:0] a_nib,
  input  logic [EW-1:0] b_nib,
  input  logic          a_sgn,
  input  logic          b_sgn,
  output logic [AW-1:0] d_o
);
  localparam int PW = 2 * EW + 2;

  logic signed [EW:0]   a_x, b_x;
  logic signed [PW-1:0] prod;
  logic [AW-1:0]        prod_ext, acc_q, acc_nx, d_q;

  assign a_x      = {a_sgn & a_nib[EW-1], a_nib};
  assign b_x      = {b_sgn & b_nib[EW-1], b_nib};
  assign prod     = PW'(a_x) * PW'(b_x);
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign acc_nx   = acc_q + prod_ext;

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (load) acc_q <= c_i;
    else if (step) acc_q <= acc_nx;
  end

  always_ff @(posedge clk) begin
    if (rst)       d_q <= '0;
    else if (last) d_q <= acc_nx;
  end

  assign d_o = d_q;
endmodule

// File: rtl/imma_seq.sv
// Idle/run sequencer: accepts start only while idle and counts DEPTH steps.
module imma_seq #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(DEPTH);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q && (cnt_q == CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/imma_tile_engine.sv
module imma_tile_engine #(
  parameter int ROWS  = imma_pkg::ROWS_DEF,
  parameter int COLS  = imma_pkg::COLS_DEF,
  parameter int DEPTH = imma_pkg::DEPTH_DEF,
  parameter int EW    = imma_pkg::EW_DEF,
  parameter int AW    = imma_pkg::AW_DEF
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic                        a_signed_i,
  input  logic                        b_signed_i,
  input  logic [ROWS*DEPTH*EW-1:0]    a_vec_i,
  input  logic [COLS*DEPTH*EW-1:0]    b_vec_i,
  input  logic [ROWS*COLS*AW-1:0]     c_vec_i,
  output logic [ROWS*COLS*AW-1:0]     d_vec_o,
  output logic                        busy_o,
  output logic                        done_o
);
  logic load, step, last;
  logic a_sgn, b_sgn;
  logic [ROWS*EW-1:0] a_nib;
  logic [COLS*EW-1:0] b_nib;

  imma_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load_o(load), .step_o(step), .last_o(last),
    .busy_o(busy_o), .done_o(done_o)
  );

  imma_operand_shift #(.LANES(ROWS), .DEPTH(DEPTH), .EW(EW)) u_a (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .sgn_i(a_signed_i), .vec_i(a_vec_i), .sgn_o(a_sgn), .nib_o(a_nib)
  );

  imma_operand_shift #(.LANES(COLS), .DEPTH(DEPTH), .EW(EW)) u_b (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .sgn_i(b_signed_i), .vec_i(b_vec_i), .sgn_o(b_sgn), .nib_o(b_nib)
  );

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_col
      localparam int IDX = i * COLS + j;
      imma_mac_cell #(.EW(EW), .AW(AW)) u_cell (
        .clk(clk), .rst(rst), .load(load), .step(step), .last(last),
        .c_i(c_vec_i[IDX*AW +: AW]),
        .a_nib(a_nib[i*EW +: EW]), .b_nib(b_nib[j*EW +: EW]),
        .a_sgn(a_sgn), .b_sgn(b_sgn),
        .d_o(d_vec_o[IDX*AW +: AW])
      );
    end
  end
endmodule

// File: rtl/imma_tile_checker.sv
module imma_tile_checker #(
  parameter int DW    = 2048,
  parameter int DEPTH = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] d_vec_o
);
  localparam int RW = $clog2(DEPTH) + 1;

  logic [RW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)          run_len <= '0;
    else if (!busy_o) run_len <= '0;
    else              run_len <= run_len + 1'b1;
  end

  AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o |=> busy_o);                                // R5
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done_o |-> run_len == RW'(DEPTH));                             // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);                                           // R7
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));                                          // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(d_vec_o));                                 // R8
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    done_o && start_i |=> busy_o);                                 // R9
endmodule

bind imma_tile_engine imma_tile_checker #(
  .DW(ROWS*COLS*AW), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .d_vec_o(d_vec_o)
);

// File: tb/sim_imma_tile_engine.sv
`timescale 1ns/1ps
module sim_imma_tile_engine;
  localparam int R = 8, C = 8, K = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, a_signed_i = 1'b0, b_signed_i = 1'b0;
  logic [R*K*4-1:0]  a_vec_i = '0;
  logic [C*K*4-1:0]  b_vec_i = '0;
  logic [R*C*32-1:0] c_vec_i = '0;
  logic [R*C*32-1:0] d_vec_o;
  logic busy_o, done_o;

  always #2.5 clk = ~clk;

  imma_tile_engine u0 (
    .clk(clk), .rst(rst), .start_i(start_i),
    .a_signed_i(a_signed_i), .b_signed_i(b_signed_i),
    .a_vec_i(a_vec_i), .b_vec_i(b_vec_i), .c_vec_i(c_vec_i),
    .d_vec_o(d_vec_o), .busy_o(busy_o), .done_o(done_o)
  );

  // Behavioural reference model
  bit m_busy, m_done;
  int m_cnt;
  logic [R*C*32-1:0] m_d, m_pend;
  int vectors = 0, fails = 0;
  string tag = "R10";

  function automatic int ext4(logic [3:0] v, bit s);
    if (s) return int'($signed(v));
    return int'(v);
  endfunction

  function automatic logic [R*C*32-1:0] ref_tile(
      logic [R*K*4-1:0] a, logic [C*K*4-1:0] b, logic [R*C*32-1:0] cc,
      bit as, bit bs);
    logic [R*C*32-1:0] res;
    for (int i = 0; i < R; i++)
      for (int j = 0; j < C; j++) begin
        logic [31:0] s;
        s = cc[(i*C+j)*32 +: 32];
        for (int k = 0; k < K; k++)
          s = s + 32'(ext4(a[i*K*4 + k*4 +: 4], as) * ext4(b[j*K*4 + k*4 +: 4], bs));
        res[(i*C+j)*32 +: 32] = s;
      end
    return res;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_d = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == K) begin
          m_busy = 0; m_done = 1; m_d = m_pend;
        end
      end else if (start_i) begin
        m_pend = ref_tile(a_vec_i, b_vec_i, c_vec_i, a_signed_i, b_signed_i);
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  task automatic compare();
    vectors++;
    if (busy_o !== m_busy || done_o !== m_done || d_vec_o !== m_d) begin
      fails++;
      if (busy_o !== m_busy)
        $display("FAIL %s busy actual %b expected %b", tag, busy_o, m_busy);
      if (done_o !== m_done)
        $display("FAIL %s done actual %b expected %b", tag, done_o, m_done);
      if (d_vec_o !== m_d)
        $display("FAIL %s d actual %h expected %h", tag, d_vec_o, m_d);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic rand_ops(bit as, bit bs);
    for (int w = 0; w < R*K*4/32; w++) a_vec_i[w*32 +: 32] = $urandom;
    for (int w = 0; w < C*K*4/32; w++) b_vec_i[w*32 +: 32] = $urandom;
    for (int w = 0; w < R*C; w++) c_vec_i[w*32 +: 32] = $urandom;
    a_signed_i = as; b_signed_i = bs;
  endtask

  task automatic start_pulse();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 3*K && !m_done; n++) tick();
  endtask

  task automatic run_tile(bit as, bit bs);
    rand_ops(as, bs);
    start_pulse();
    wait_done();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired: actual no finish expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R10"; compare();
    rst = 1'b0;
    tick();

    tag = "R1"; run_tile(0, 0);
    tag = "R2"; run_tile(0, 0);
    tag = "R3"; run_tile(1, 0);
    tag = "R3"; run_tile(0, 1);
    tag = "R3"; run_tile(1, 1);

    // R4: all-max unsigned products overflow a large addend
    tag = "R4";
    a_vec_i = '1; b_vec_i = '1;
    for (int w = 0; w < R*C; w++) c_vec_i[w*32 +: 32] = 32'hFFFF_F000 + 32'(w);
    a_signed_i = 0; b_signed_i = 0;
    start_pulse(); wait_done(); tick();

    // R5: inputs change right after acceptance
    tag = "R5";
    rand_ops(1, 0);
    start_pulse();
    rand_ops(0, 1);
    wait_done(); tick();

    // R6: start held through a run, including its last busy cycle
    tag = "R6";
    rand_ops(0, 0);
    start_pulse();
    rand_ops(1, 1);
    start_i = 1'b1;
    for (int n = 0; n < 3*K && !m_done; n++) begin
      if (m_cnt == K - 1) start_i = 1'b1;
      tick();
      if (m_busy && m_cnt == K - 1) start_i = 1'b1;
      if (m_done) start_i = 1'b0;
    end
    start_i = 1'b0;
    // R6: the extra request must not have started another tile
    repeat (3) tick();

    // R9 and R8: start in the done cycle; old result must hold meanwhile
    tag = "R9";
    rand_ops(1, 0);
    start_pulse();
    wait_done();
    rand_ops(0, 1);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    tag = "R8";
    wait_done();
    repeat (4) tick();

    tag = "R7"; run_tile(1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule